// File: doc/BRIEF.md
# PCIe Slot Reset Sequencer

This block brings two M.2 endpoint slots out of reset at boot, and again on request, by programming an 8-bit I2C I/O expander whose pins carry the slots' active-low reset lines. When a sequence is launched, it first writes the expander's output register to all zeros. Only then does it write the direction register, so that the two reset pins become outputs already driven low and never glitch high. It then reads the expander's input register to learn whether the stacked card is present. Next it waits for power-good, holds the resets low for a fixed interval, releases them by writing the output register again, and waits a settle interval before it reports done.

A small open-drain I2C master inside the block performs single-register writes (START, address+W, register, data, STOP) and single-register reads (START, address+W, register, repeated START, address+R, one byte answered with NACK, STOP). The SCL rate comes from a divider parameter. The hold and settle intervals are counted in system clocks derived from a clock-frequency parameter, so they can be shortened for test. A NACK at any byte aborts the sequence and leaves a sticky error code that names the failing step.

The control FSM has these states: IDLE, ASSERT_OUT (write output reg 0x01 = 0x00), SET_DIR (write direction reg 0x03 = 0xFC), READ_IN (read input reg 0x00), WAIT_PWR, HOLD, RELEASE (write output reg 0x01 = 0x03), SETTLE, DONE and FAULT. Its transitions are:
- IDLE, DONE or FAULT go to ASSERT_OUT on start or warm_rst.
- ASSERT_OUT goes to SET_DIR, SET_DIR to READ_IN and READ_IN to WAIT_PWR, each when its transfer is acknowledged.
- ASSERT_OUT, SET_DIR, READ_IN and RELEASE go to FAULT when their transfer is NACKed.
- WAIT_PWR goes to HOLD when power is good.
- HOLD goes back to WAIT_PWR if power-good drops, and goes to RELEASE when the hold interval expires.
- RELEASE goes to SETTLE when its transfer is acknowledged.
- SETTLE goes to DONE when the settle interval expires.

Top module: `slot_reset_seq`

## Requirements
- R1: After reset, busy, done and err are 0, err_step is 0, perst_mirror is 2'b00, slot_present is 0, and both bus lines are released (scl_low = 0, sda_low = 0).
- R2: A launched sequence addresses the expander at 7-bit address 0x41, with address byte 0x82 for writes and 0x83 for reads. It writes register 0x01 = 0x00 first and register 0x03 = 0xFC second, before any other write.
- R3: The block reads register 0x00 using a repeated START and ends the data byte with a NACK. slot_present becomes the inverse of bit 2 of that byte, so 1 means present.
- R4: While pwr_good is low after the input read, no release write occurs, busy stays 1 and perst_mirror stays 2'b00.
- R5: The release write starts no earlier than HOLD_MS*CLK_HZ/1000 clocks after pwr_good is seen high. If pwr_good drops during the hold, the count restarts from zero when pwr_good returns.
- R6: The release writes register 0x01 = 0x03. perst_mirror becomes 2'b11 only after that write is acknowledged.
- R7: done rises, and busy falls, SETTLE_MS*CLK_HZ/1000 clocks after the release write completes.
- R8: A start or warm_rst pulse while not busy launches the full sequence again. done and err clear on the clock edge that launches it, and perst_mirror returns to 2'b00.
- R9: A start or warm_rst pulse while busy is ignored, and no extra bus transfers result.
- R10: A NACK aborts the sequence: err = 1, busy = 0, done = 0 and perst_mirror = 2'b00. err_step names the step: 1 for the output-low write, 2 for the direction write, 3 for the input read, 4 for the release write.
- R11: SDA changes only while SCL is low during data and acknowledge bits. Consecutive SCL rising edges are at least 4*SCL_DIV clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Slot supply rails are stable |
| start | input | 1 | Boot sequence request (pulse) |
| warm_rst | input | 1 | Warm reset request (pulse) |
| scl_low | output | 1 | 1 pulls the SCL line low, 0 releases it |
| sda_low | output | 1 | 1 pulls the SDA line low, 0 releases it |
| sda_in | input | 1 | Resolved level of the SDA line |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | The last sequence completed and slots are released |
| err | output | 1 | Sticky abort flag set by a NACK |
| err_step | output | 3 | Step that failed (1 to 4, 0 if none) |
| slot_present | output | 1 | Stacked card present (inverse of expander input bit 2) |
| perst_mirror | output | 2 | Last acknowledged value of the two reset pins |

## Verification
The bench builds the block with CLK_HZ = 1_000_000, HOLD_MS = 2, SETTLE_MS = 1 and SCL_DIV = 2. This makes the hold interval 2000 clocks, the settle interval 1000 clocks and each bus bit 8 clocks. A complete sequence therefore fits in a few thousand cycles. The short intervals allow the power-good glitch, several input-byte patterns and a NACK injected at each of the four transfers to be run within one bench. An expander model on the bus records the time of each register write, and the hold and settle windows are checked against those times.

// File: rtl/slot_rst_pkg.sv
package slot_rst_pkg;

    typedef enum logic [3:0] {
        SQ_IDLE, SQ_ASSERT_OUT, SQ_SET_DIR, SQ_READ_IN, SQ_WAIT_PWR,
        SQ_HOLD, SQ_RELEASE, SQ_SETTLE, SQ_DONE, SQ_FAULT
    } seq_state_t;

    typedef enum logic [2:0] {
        BM_IDLE, BM_START, BM_BIT, BM_RSTART, BM_STOP
    } bus_state_t;

    typedef enum logic [2:0] {
        STEP_NONE = 3'd0, STEP_OUT_LOW = 3'd1, STEP_DIR = 3'd2,
        STEP_READ = 3'd3, STEP_OUT_HIGH = 3'd4
    } step_t;

    localparam logic [7:0] REG_INPUT   = 8'h00;
    localparam logic [7:0] REG_OUTPUT  = 8'h01;
    localparam logic [7:0] REG_DIR     = 8'h03;
    localparam logic [7:0] VAL_ASSERT  = 8'h00;
    localparam logic [7:0] VAL_RELEASE = 8'h03;
    localparam logic [7:0] VAL_DIR     = 8'hFC;
    localparam int unsigned PRESENT_BIT = 2;

endpackage

// File: rtl/exp_bus_master.sv
module exp_bus_master #(
    parameter int unsigned SCL_DIV    = 312,
    parameter logic [6:0]  DEV_ADDR   = 7'h41,
    parameter int unsigned SAMPLE_BIT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       rd,
    input  logic [7:0] reg_addr,
    input  logic [7:0] wdata,
    output logic       xfer_done,
    output logic       xfer_nack,
    output logic       rd_bit,
    output logic       scl_low,
    output logic       sda_low,
    input  logic       sda_in
);
    import slot_rst_pkg::*;

    localparam int unsigned DIVW = $clog2(SCL_DIV + 1);

    bus_state_t      bst;
    logic [1:0]      q;
    logic [DIVW-1:0] div_cnt;
    logic [3:0]      bit_cnt;
    logic [1:0]      byte_idx;
    logic [7:0]      sh;
    logic            rd_mode, nack_seen, tick, recv;

    assign tick      = (div_cnt == DIVW'(SCL_DIV - 1));
    assign recv      = rd_mode && (byte_idx == 2'd3);
    assign xfer_nack = nack_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bst <= BM_IDLE; q <= 2'd0; div_cnt <= '0; bit_cnt <= 4'd0;
            byte_idx <= 2'd0; sh <= 8'h00; rd_mode <= 1'b0;
            nack_seen <= 1'b0; rd_bit <= 1'b0; xfer_done <= 1'b0;
        end else begin
            xfer_done <= 1'b0;
            if (bst == BM_IDLE) begin
                div_cnt <= '0;
                q       <= 2'd0;
                if (go) begin
                    bst <= BM_START; rd_mode <= rd; byte_idx <= 2'd0;
                    sh <= {DEV_ADDR, 1'b0}; nack_seen <= 1'b0; bit_cnt <= 4'd0;
                end
            end else if (!tick) begin
                div_cnt <= div_cnt + 1'b1;
            end else begin
                div_cnt <= '0;
                q       <= q + 2'd1;
                if (q == 2'd2 && bst == BM_BIT) begin
                    if (bit_cnt == 4'd8) begin
                        if (!recv && sda_in) nack_seen <= 1'b1;
                    end else if (recv) begin
                        sh <= {sh[6:0], sda_in};
                    end
                end
                if (q == 2'd3) begin
                    unique case (bst)
                        BM_START, BM_RSTART: begin
                            bst <= BM_BIT; bit_cnt <= 4'd0;
                        end
                        BM_BIT: begin
                            if (bit_cnt != 4'd8) begin
                                bit_cnt <= bit_cnt + 4'd1;
                                if (!recv) sh <= {sh[6:0], 1'b0};
                            end else begin
                                bit_cnt <= 4'd0;
                                if (nack_seen) begin
                                    bst <= BM_STOP;
                                end else begin
                                    unique case (byte_idx)
                                        2'd0: begin byte_idx <= 2'd1; sh <= reg_addr; end
                                        2'd1: begin
                                            byte_idx <= 2'd2;
                                            if (rd_mode) begin
                                                bst <= BM_RSTART; sh <= {DEV_ADDR, 1'b1};
                                            end else begin
                                                sh <= wdata;
                                            end
                                        end
                                        2'd2: begin
                                            if (rd_mode) byte_idx <= 2'd3;
                                            else         bst <= BM_STOP;
                                        end
                                        default: begin
                                            rd_bit <= sh[SAMPLE_BIT];
                                            bst    <= BM_STOP;
                                        end
                                    endcase
                                end
                            end
                        end
                        BM_STOP: begin
                            bst <= BM_IDLE; xfer_done <= 1'b1;
                        end
                        default: bst <= BM_IDLE;
                    endcase
                end
            end
        end
    end

    always_comb begin
        scl_low = 1'b0;
        sda_low = 1'b0;
        unique case (bst)
            BM_IDLE:   ;
            BM_START:  begin scl_low = (q == 2'd3); sda_low = (q != 2'd0); end
            BM_RSTART: begin scl_low = (q == 2'd0 || q == 2'd3); sda_low = (q >= 2'd2); end
            BM_BIT: begin
                scl_low = (q == 2'd0 || q == 2'd3);
                sda_low = (bit_cnt != 4'd8 && !recv) ? ~sh[7] : 1'b0;
            end
            BM_STOP:   begin scl_low = (q == 2'd0); sda_low = (q < 2'd2); end
            default:   ;
        endcase
    end

    // R11: data line held steady while the clock line is high inside a bit
    p_sda_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bst == BM_BIT && $past(bst) == BM_BIT && !scl_low && !$past(scl_low))
        |-> $stable(sda_low));

endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
    parameter int unsigned W = 27
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         expired
);
    logic [W-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             count <= '0;
        else if (load)          count <= value;
        else if (count != '0)   count <= count - 1'b1;
    end

    assign expired = (count == '0);

    // R5: once expired the timer stays expired until reloaded
    p_expired_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired);

endmodule

// File: rtl/perst_seq_ctrl.sv
module perst_seq_ctrl #(
    parameter int unsigned HOLD_CYC   = 2000,
    parameter int unsigned SETTLE_CYC = 1000,
    parameter int unsigned TW         = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_good,
    input  logic          start,
    input  logic          warm_rst,
    output logic          go,
    output logic          rd,
    output logic [7:0]    reg_addr,
    output logic [7:0]    wdata,
    input  logic          xfer_done,
    input  logic          xfer_nack,
    input  logic          rd_bit,
    output logic          t_load,
    output logic [TW-1:0] t_value,
    input  logic          t_expired,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [2:0]    err_step,
    output logic          slot_present,
    output logic [1:0]    perst_mirror
);
    import slot_rst_pkg::*;

    seq_state_t state, nxt;
    step_t      step_q, step_now;
    logic       issued, launch;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SQ_IDLE, SQ_DONE, SQ_FAULT: if (start || warm_rst) nxt = SQ_ASSERT_OUT;
            SQ_ASSERT_OUT: if (xfer_done) nxt = xfer_nack ? SQ_FAULT : SQ_SET_DIR;
            SQ_SET_DIR:    if (xfer_done) nxt = xfer_nack ? SQ_FAULT : SQ_READ_IN;
            SQ_READ_IN:    if (xfer_done) nxt = xfer_nack ? SQ_FAULT : SQ_WAIT_PWR;
            SQ_WAIT_PWR:   if (pwr_good) nxt = SQ_HOLD;
            SQ_HOLD: begin
                if (!pwr_good)      nxt = SQ_WAIT_PWR;
                else if (t_expired) nxt = SQ_RELEASE;
            end
            SQ_RELEASE:    if (xfer_done) nxt = xfer_nack ? SQ_FAULT : SQ_SETTLE;
            SQ_SETTLE:     if (t_expired) nxt = SQ_DONE;
            default:       nxt = SQ_IDLE;
        endcase
    end

    always_comb begin
        go = 1'b0; rd = 1'b0; reg_addr = REG_OUTPUT; wdata = VAL_ASSERT;
        busy = 1'b1; step_now = STEP_NONE;
        unique case (state)
            SQ_IDLE, SQ_DONE, SQ_FAULT: busy = 1'b0;
            SQ_ASSERT_OUT: begin go = !issued; step_now = STEP_OUT_LOW; end
            SQ_SET_DIR: begin
                go = !issued; reg_addr = REG_DIR; wdata = VAL_DIR; step_now = STEP_DIR;
            end
            SQ_READ_IN: begin
                go = !issued; rd = 1'b1; reg_addr = REG_INPUT; step_now = STEP_READ;
            end
            SQ_RELEASE: begin go = !issued; wdata = VAL_RELEASE; step_now = STEP_OUT_HIGH; end
            default: ;
        endcase
        done    = (state == SQ_DONE);
        launch  = !busy && (start || warm_rst);
        t_load  = (nxt == SQ_HOLD && state != SQ_HOLD) || (nxt == SQ_SETTLE && state != SQ_SETTLE);
        t_value = (nxt == SQ_HOLD) ? TW'(HOLD_CYC - 1) : TW'(SETTLE_CYC - 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issued <= 1'b0; err <= 1'b0; step_q <= STEP_NONE;
            slot_present <= 1'b0; perst_mirror <= 2'b00;
        end else begin
            if (go)        issued <= 1'b1;
            if (xfer_done) issued <= 1'b0;
            if (launch) begin
                err <= 1'b0; step_q <= STEP_NONE; perst_mirror <= 2'b00;
            end
            if (xfer_done) begin
                if (xfer_nack) begin
                    err <= 1'b1; step_q <= step_now;
                end else begin
                    if (state == SQ_READ_IN) slot_present <= ~rd_bit;
                    if (state == SQ_RELEASE) perst_mirror <= 2'b11;
                end
            end
        end
    end

    assign err_step = step_q;

    // R10: an aborted sequence is never reported busy
    p_err_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);
    // R4: slots stay held while waiting for power
    p_held_waiting_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_WAIT_PWR) |-> (perst_mirror == 2'b00));
    // R5: losing power during the hold returns to the wait
    p_pg_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_HOLD && !pwr_good) |=> (state == SQ_WAIT_PWR));
    // R9: a request during the hold does not disturb it
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_HOLD && (start || warm_rst) && pwr_good && !t_expired)
        |=> (state == SQ_HOLD));
    // R8: relaunching clears the done and error reports
    p_relaunch_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == SQ_DONE || state == SQ_FAULT) && (start || warm_rst))
        |=> (!done && !err));

endmodule

// File: rtl/slot_reset_seq.sv
module slot_reset_seq #(
    parameter int unsigned CLK_HZ    = 125_000_000,
    parameter int unsigned HOLD_MS   = 1000,
    parameter int unsigned SETTLE_MS = 100,
    parameter int unsigned SCL_DIV   = 312
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_good,
    input  logic       start,
    input  logic       warm_rst,
    output logic       scl_low,
    output logic       sda_low,
    input  logic       sda_in,
    output logic       busy,
    output logic       done,
    output logic       err,
    output logic [2:0] err_step,
    output logic       slot_present,
    output logic [1:0] perst_mirror
);
    localparam int unsigned CYC_PER_MS = CLK_HZ / 1000;
    localparam int unsigned HOLD_CYC   = CYC_PER_MS * HOLD_MS;
    localparam int unsigned SETTLE_CYC = CYC_PER_MS * SETTLE_MS;
    localparam int unsigned MAX_CYC    = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
    localparam int unsigned TW         = $clog2(MAX_CYC + 1);

    logic          go, rd, xfer_done, xfer_nack, rd_bit, t_load, t_expired;
    logic [7:0]    reg_addr, wdata;
    logic [TW-1:0] t_value;

    perst_seq_ctrl #(.HOLD_CYC(HOLD_CYC), .SETTLE_CYC(SETTLE_CYC), .TW(TW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .start(start), .warm_rst(warm_rst),
        .go(go), .rd(rd), .reg_addr(reg_addr), .wdata(wdata),
        .xfer_done(xfer_done), .xfer_nack(xfer_nack), .rd_bit(rd_bit),
        .t_load(t_load), .t_value(t_value), .t_expired(t_expired),
        .busy(busy), .done(done), .err(err), .err_step(err_step),
        .slot_present(slot_present), .perst_mirror(perst_mirror)
    );

    exp_bus_master #(.SCL_DIV(SCL_DIV), .DEV_ADDR(7'h41),
                     .SAMPLE_BIT(slot_rst_pkg::PRESENT_BIT)) u_bus (
        .clk(clk), .rst_n(rst_n), .go(go), .rd(rd), .reg_addr(reg_addr), .wdata(wdata),
        .xfer_done(xfer_done), .xfer_nack(xfer_nack), .rd_bit(rd_bit),
        .scl_low(scl_low), .sda_low(sda_low), .sda_in(sda_in)
    );

    interval_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .value(t_value), .expired(t_expired)
    );

endmodule

// File: tb/slot_reset_seq_test.sv
module slot_reset_seq_test;
    localparam int unsigned SCL_DIV    = 2;
    localparam int          HOLD_CYC   = 2000;
    localparam int          SETTLE_CYC = 1000;

    logic clk = 1'b0, rst_n = 1'b0, pwr_good = 1'b0, start = 1'b0, warm_rst = 1'b0;
    logic scl_low, sda_low, sda_in, busy, done, err, slot_present;
    logic [2:0] err_step;
    logic [1:0] perst_mirror;

    always #4 clk = ~clk;

    slot_reset_seq #(.CLK_HZ(1_000_000), .HOLD_MS(2), .SETTLE_MS(1), .SCL_DIV(SCL_DIV)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .start(start), .warm_rst(warm_rst),
        .scl_low(scl_low), .sda_low(sda_low), .sda_in(sda_in), .busy(busy), .done(done),
        .err(err), .err_step(err_step), .slot_present(slot_present), .perst_mirror(perst_mirror)
    );

    // expander model on the bus
    logic       s_drive = 1'b0;
    wire        scl_line = ~scl_low;
    wire        sda_line = ~(sda_low | s_drive);
    assign sda_in = sda_line;

    logic       prev_scl = 1'b1, prev_sda = 1'b1, s_active = 1'b0, s_ack_ph = 1'b0;
    logic       s_rd = 1'b0, in_txn = 1'b0, ack;
    int         s_bitc = 0, s_bytec = 0, txn_no = 0, nack_txn = 0, log_n = 0;
    logic [7:0] s_sh = 8'h00, s_ptr = 8'h00, s_rdb = 8'h00, in_val = 8'hFB;
    logic [7:0] out_reg = 8'hFF, dir_reg = 8'hFF;
    logic [7:0] log_reg [16];
    logic [7:0] log_dat [16];
    longint     log_t [16];
    longint     cyc = 0, last_rise = 0, min_rise = 1000000;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (scl_line && prev_scl) begin
            if (prev_sda && !sda_line) begin
                if (!in_txn) begin txn_no = txn_no + 1; in_txn = 1'b1; end
                s_active = 1'b1; s_bitc = 0; s_bytec = 0; s_ack_ph = 1'b0; s_rd = 1'b0; s_drive = 1'b0;
            end else if (!prev_sda && sda_line) begin
                in_txn = 1'b0; s_active = 1'b0; s_drive = 1'b0;
            end
        end
        if (scl_line && !prev_scl) begin
            if (last_rise != 0 && cyc - last_rise < min_rise) min_rise = cyc - last_rise;
            last_rise = cyc;
            if (s_active && !s_ack_ph && s_bitc < 8) begin
                s_sh = {s_sh[6:0], sda_line}; s_bitc = s_bitc + 1;
            end
        end
        if (!scl_line && prev_scl && s_active) begin
            if (s_ack_ph) begin
                s_ack_ph = 1'b0; s_bitc = 0; s_drive = 1'b0;
                if (s_rd && s_bytec == 1) s_drive = ~s_rdb[7];
                else if (s_rd) s_active = 1'b0;
            end else if (s_bitc == 8) begin
                s_ack_ph = 1'b1;
                if (s_rd && s_bytec == 1) begin
                    s_drive = 1'b0; s_bytec = 2;
                end else begin
                    ack = 1'b1;
                    if (s_bytec == 0) begin
                        if (s_sh[7:1] != 7'h41 || txn_no == nack_txn) ack = 1'b0;
                        else begin s_rd = s_sh[0]; s_rdb = in_val; end
                    end else if (s_bytec == 1) begin
                        s_ptr = s_sh;
                    end else begin
                        if (log_n < 16) begin
                            log_reg[log_n] = s_ptr; log_dat[log_n] = s_sh; log_t[log_n] = cyc;
                            log_n = log_n + 1;
                        end
                        if (s_ptr == 8'h01) out_reg = s_sh;
                        if (s_ptr == 8'h03) dir_reg = s_sh;
                    end
                    s_bytec = s_bytec + 1;
                    s_drive = ack;
                    if (!ack) s_active = 1'b0;
                end
            end else if (s_rd && s_bitc > 0) begin
                s_drive = ~s_rdb[7 - s_bitc];
            end
        end
        prev_scl = scl_line;
        prev_sda = sda_line;
    end

    int n_chk = 0, n_bad = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input longint act, input longint lo, input longint hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic pulse(input bit warm);
        @(negedge clk);
        if (warm) warm_rst = 1'b1; else start = 1'b1;
        @(negedge clk);
        warm_rst = 1'b0; start = 1'b0;
    endtask

    task automatic wait_idle(input string tag, output longint t_end);
        int k = 0;
        while (busy && k < 8000) begin @(negedge clk); k++; end
        t_end = cyc;
        chk(tag, busy, 0);
    endtask

    // {input register byte, expected slot_present}
    localparam logic [8:0] PRES_VEC [4] = '{9'h1FE, 9'h1F7, 9'h008, 9'h001};
    // {register, data} of the three writes, in order
    localparam logic [15:0] WR_VEC [3] = '{16'h0100, 16'h03FC, 16'h0103};

    initial begin
        longint t0, t1, t_end;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);       chk("R1 done", done, 0);
        chk("R1 err", err, 0);         chk("R1 err_step", err_step, 0);
        chk("R1 perst_mirror", perst_mirror, 0); chk("R1 slot_present", slot_present, 0);
        chk("R1 scl_low", scl_low, 0); chk("R1 sda_low", sda_low, 0);

        // R4: launch with power not good
        pulse(1'b0);
        repeat (6000) @(negedge clk);
        chk("R4 writes before power", log_n, 2);
        chk("R4 busy", busy, 1);
        chk("R4 perst_mirror", perst_mirror, 0);
        chk("R2 first write", {log_reg[0], log_dat[0]}, 16'h0100);
        chk("R2 second write", {log_reg[1], log_dat[1]}, 16'h03FC);
        chk("R2 dir reg", dir_reg, 8'hFC);
        chk("R3 present from 0xFB", slot_present, 1);

        // R5: power good with a glitch, R9: request during hold ignored
        pwr_good = 1'b1;
        repeat (1000) @(negedge clk);
        pwr_good = 1'b0;
        chk("R5 no release mid-hold", log_n, 2);
        repeat (10) @(negedge clk);
        pwr_good = 1'b1;
        t1 = cyc;
        repeat (100) @(negedge clk);
        pulse(1'b1);
        wait_idle("R7 finished", t_end);
        chk("R9 no extra transfers", log_n, 3);
        chk("R6 release write", {log_reg[2], log_dat[2]}, 16'h0103);
        chk_rng("R5 hold after power", log_t[2] - t1, HOLD_CYC, HOLD_CYC + 400);
        chk_rng("R7 settle after release", t_end - log_t[2], SETTLE_CYC, SETTLE_CYC + 100);
        chk("R7 done", done, 1);
        chk("R6 perst_mirror", perst_mirror, 3);
        chk("R6 out reg", out_reg, 8'h03);

        // table of input patterns, alternating warm and boot requests (R8)
        for (int i = 0; i < 4; i++) begin
            in_val = PRES_VEC[i][8:1];
            log_n  = 0;
            pulse(i % 2 == 0);
            chk("R8 done cleared", done, 0);
            chk("R8 busy again", busy, 1);
            chk("R8 mirror reasserted", perst_mirror, 0);
            wait_idle("R8 rerun", t_end);
            chk("R8 rerun done", done, 1);
            chk("R8 rerun writes", log_n, 3);
            for (int j = 0; j < 3; j++)
                chk("R2 R6 write order", {log_reg[j], log_dat[j]}, WR_VEC[j]);
            chk("R3 slot_present", slot_present, PRES_VEC[i][0]);
        end

        // R10: NACK at each of the four transfers
        for (int k = 1; k <= 4; k++) begin
            txn_no = 0; nack_txn = k; log_n = 0;
            pulse(1'b0);
            chk("R10 err cleared on launch", err, 0);
            wait_idle("R10 abort", t_end);
            chk("R10 err", err, 1);
            chk("R10 err_step", err_step, k);
            chk("R10 done", done, 0);
            chk("R10 perst_mirror", perst_mirror, 0);
            nack_txn = 0;
        end
        chk("R10 out reg held low", out_reg, 8'h00);
        chk("R11 scl rise spacing", min_rise, 4 * SCL_DIV);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule